// File: doc/BRIEF.md
# Corner Logo Overlay for a Pixel Stream

This block sits inline in a parallel pixel stream carrying 24-bit colour, a blank flag and horizontal and vertical sync. It works out the position of the current pixel from the timing signals alone. The column count starts at each falling edge of blank. The row count is cleared by vsync and advances at the end of each active line. Inside a square window pinned to the top-right corner of the active picture, the incoming colour is replaced by a pixel from an on-chip logo store. Everywhere else the incoming colour is forwarded.

The logo store keeps one 24-bit word per pixel. Each word holds blue in the upper byte, green in the middle byte and red in the lower byte. Rows are kept bottom-first, so the store reorders both the row and the bytes on the way out. The store has a one-clock read. Colour, blank and both syncs therefore leave the block exactly one clock after they enter, and the timing stays aligned with the picture. With the default parameters the picture is 1280 pixels wide and the window is 128 by 128 pixels, covering columns 1152 to 1279 and rows 0 to 127.

Top module: `logo_overlay`

## Requirements
- R1: `blank_o`, `hsync_o` and `vsync_o` equal `blank_i`, `hsync_i` and `vsync_i` from one clock earlier, unchanged.
- R2: The first pixel with `blank_i` low after a cycle with `blank_i` high is column 0. Each following pixel with `blank_i` low is one column higher.
- R3: A cycle with `vsync_i` high (active-high) clears the row count. Each rising edge of `blank_i` (end of an active line) advances it, so the first active line after vsync is row 0.
- R4: The window covers columns `ACTIVE_W-LOGO_W` to `ACTIVE_W-1` and rows 0 to `LOGO_H-1` of pixels with `blank_i` low. With the defaults these are columns 1152 to 1279 and rows 0 to 127.
- R5: For a pixel inside the window, `rgb_o` one clock later is the logo pixel with red in bits [23:16], green in [15:8] and blue in [7:0]. The stored word for stored row s and logo column c is {blue, green, red}, where blue = (37*s XOR c) mod 256, green = (5*c + s) mod 256 and red = bitwise NOT of ((c XOR 4*s) mod 256), each 8 bits wide.
- R6: Storage is bottom-up. Screen row y inside the window reads stored row `LOGO_H-1-y`, and logo column c = column − (`ACTIVE_W-LOGO_W`).
- R7: Outside the window, or while `blank_i` is high, `rgb_o` equals `rgb_i` from one clock earlier.
- R8: Pixels at column `ACTIVE_W` or beyond, on an over-long line, pass through unchanged, as do rows at `LOGO_H` or beyond.
- R9: Synchronous active-high reset. While `rst` is high, the outputs after a clock edge are `blank_o`=1, `hsync_o`=0, `vsync_o`=0 and `rgb_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rgb_i | input | 24 | Incoming colour, red [23:16], green [15:8], blue [7:0] |
| blank_i | input | 1 | High outside the active picture |
| hsync_i | input | 1 | Horizontal sync, passed through |
| vsync_i | input | 1 | Vertical sync, active high, clears the row count |
| rgb_o | output | 24 | Outgoing colour, one clock after input |
| blank_o | output | 1 | Delayed blank |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |

## Verification
The assertions assume a few things about the input timing. Blank is held high through the whole horizontal and vertical blanking. Vsync is asserted only while blank is high. Every active line is followed by at least one blank cycle, so that each line end gives one rising edge of blank. The stimulus follows these rules. It sends several frames of a reduced-size raster with a 24-pixel picture, an 8x6 logo and nine active lines, so the row count passes beyond the logo height. It pulses hsync inside each horizontal blank and holds vsync high for one full blank line. The last frame lengthens every active line by three pixels to exercise columns past the picture width.

// File: rtl/overlay_pkg.sv
package overlay_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;

  typedef logic [PIX_W-1:0] pix_t;

  // Stored logo word for stored row srow, logo column col: {blue, green, red}
  function automatic pix_t logo_word(int unsigned srow, int unsigned col);
    logic [CH_W-1:0] b, g, r;
    b = CH_W'((srow * 37) ^ col);
    g = CH_W'(col * 5 + srow);
    r = ~CH_W'(col ^ (srow * 4));
    return {b, g, r};
  endfunction

  // Reorder a stored {blue, green, red} word into {red, green, blue}
  function automatic pix_t bgr_to_rgb(pix_t w);
    return {w[CH_W-1:0], w[2*CH_W-1:CH_W], w[3*CH_W-1:2*CH_W]};
  endfunction
endpackage

// File: rtl/pos_tracker.sv
module pos_tracker #(
  parameter int CNT_W = 12,
  parameter int ROW_W = 8,
  parameter int ROW_MAX = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blank,
  input  logic             vsync,
  output logic [CNT_W-1:0] col_now,
  output logic [ROW_W-1:0] row_now
);
  logic             blank_prev;
  logic [CNT_W-1:0] col_reg;
  logic [ROW_W-1:0] row_reg;
  logic             line_first;
  logic             line_end;

  assign line_first = ~blank & blank_prev;
  assign line_end   = blank & ~blank_prev;
  assign col_now    = line_first ? '0 : col_reg;
  assign row_now    = row_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_prev <= 1'b1;
      col_reg    <= '0;
      row_reg    <= '0;
    end else begin
      blank_prev <= blank;
      if (!blank && col_now != {CNT_W{1'b1}})
        col_reg <= col_now + 1'b1;
      if (vsync)
        row_reg <= '0;
      else if (line_end && row_reg != ROW_W'(ROW_MAX))
        row_reg <= row_reg + 1'b1;
    end
  end
endmodule

// File: rtl/window_map.sv
module window_map #(
  parameter int ACTIVE_W = 1280,
  parameter int LOGO_W = 128,
  parameter int LOGO_H = 128,
  parameter int CNT_W = 12,
  parameter int ROW_W = 8,
  parameter int ADDR_W = 14
) (
  input  logic              blank,
  input  logic [CNT_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  output logic              hit,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFFSET = ACTIVE_W - LOGO_W;

  function automatic logic [ADDR_W-1:0] rom_index(logic [ROW_W-1:0] r,
                                                  logic [CNT_W-1:0] c);
    logic [ROW_W-1:0] srow;
    logic [CNT_W-1:0] lcol;
    srow = ROW_W'(LOGO_H - 1) - r;
    lcol = c - CNT_W'(OFFSET);
    return ADDR_W'(srow) * ADDR_W'(LOGO_W) + ADDR_W'(lcol);
  endfunction

  assign hit = !blank
            && col >= CNT_W'(OFFSET)
            && col <  CNT_W'(ACTIVE_W)
            && row <  ROW_W'(LOGO_H);
  assign addr = rom_index(row, col);
endmodule

// File: rtl/logo_rom.sv
module logo_rom
  import overlay_pkg::*;
#(
  parameter int LOGO_W = 128,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output pix_t              word
);
  logic [ADDR_W-1:0] srow, lcol;

  assign srow = addr / ADDR_W'(LOGO_W);
  assign lcol = addr % ADDR_W'(LOGO_W);

  always_ff @(posedge clk)
    word <= logo_word(int'(srow), int'(lcol));
endmodule

// File: rtl/logo_overlay.sv
module logo_overlay
  import overlay_pkg::*;
#(
  parameter int ACTIVE_W = 1280,
  parameter int LOGO_W = 128,
  parameter int LOGO_H = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [23:0] rgb_i,
  input  logic        blank_i,
  input  logic        hsync_i,
  input  logic        vsync_i,
  output logic [23:0] rgb_o,
  output logic        blank_o,
  output logic        hsync_o,
  output logic        vsync_o
);
  localparam int CNT_W  = $clog2(ACTIVE_W) + 1;
  localparam int ROW_W  = $clog2(LOGO_H) + 1;
  localparam int ADDR_W = $clog2(LOGO_W * LOGO_H);

  logic [CNT_W-1:0]  col_now;
  logic [ROW_W-1:0]  row_now;
  logic              win_hit;
  logic [ADDR_W-1:0] rom_addr;
  pix_t              rom_word;
  pix_t              rgb_d;
  logic              hit_d;

  pos_tracker #(.CNT_W(CNT_W), .ROW_W(ROW_W), .ROW_MAX(LOGO_H)) u_pos (
    .clk(clk), .rst(rst), .blank(blank_i), .vsync(vsync_i),
    .col_now(col_now), .row_now(row_now)
  );

  window_map #(
    .ACTIVE_W(ACTIVE_W), .LOGO_W(LOGO_W), .LOGO_H(LOGO_H),
    .CNT_W(CNT_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
  ) u_win (
    .blank(blank_i), .col(col_now), .row(row_now),
    .hit(win_hit), .addr(rom_addr)
  );

  logo_rom #(.LOGO_W(LOGO_W), .ADDR_W(ADDR_W)) u_rom (
    .clk(clk), .addr(rom_addr), .word(rom_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_d   <= '0;
      hit_d   <= 1'b0;
      blank_o <= 1'b1;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      rgb_d   <= rgb_i;
      hit_d   <= win_hit;
      blank_o <= blank_i;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
    end
  end

  assign rgb_o = hit_d ? bgr_to_rgb(rom_word) : rgb_d;
endmodule

// File: rtl/overlay_checks.sv
module overlay_checks #(
  parameter int CNT_W = 12,
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [23:0]      rgb_i,
  input logic             blank_i,
  input logic             hsync_i,
  input logic             vsync_i,
  input logic [23:0]      rgb_o,
  input logic             blank_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic [CNT_W-1:0] col_now,
  input logic [ROW_W-1:0] row_now,
  input logic             win_hit
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst || !past_ok)
    {blank_o, hsync_o, vsync_o} == $past({blank_i, hsync_i, vsync_i})); // R1
  AST_COL_START: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $fell(blank_i) |-> col_now == '0); // R2
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (!blank_i && !$past(blank_i) && $past(col_now) != {CNT_W{1'b1}})
      |-> col_now == CNT_W'($past(col_now) + 1'b1)); // R2
  AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(vsync_i) |-> row_now == '0); // R3
  AST_BLANK_PASS: assert property (@(posedge clk) disable iff (rst || !past_ok)
    blank_o |-> rgb_o == $past(rgb_i)); // R7
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(win_hit) |-> rgb_o == $past(rgb_i)); // R7
  AST_RESET_OUT: assert property (@(posedge clk)
    $past(rst) |-> (blank_o && !hsync_o && !vsync_o && rgb_o == '0)); // R9
endmodule

bind logo_overlay overlay_checks #(.CNT_W(CNT_W), .ROW_W(ROW_W)) u_checks (.*);

// File: tb/logo_overlay_test.sv
module logo_overlay_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int LW = 8;
  localparam int LH = 6;
  localparam int HB = 5;
  localparam int LINES = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] rgb_i = '0;
  logic        blank_i = 1'b1, hsync_i = 1'b0, vsync_i = 1'b0;
  logic [23:0] rgb_o;
  logic        blank_o, hsync_o, vsync_o;

  int vectors = 0;
  int miscompares = 0;

  logic        exp_valid = 1'b0;
  logic [23:0] exp_rgb;
  logic        exp_blank, exp_hs, exp_vs;
  string       exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  logo_overlay #(.ACTIVE_W(AW), .LOGO_W(LW), .LOGO_H(LH)) uut (
    .clk(clk), .rst(rst), .rgb_i(rgb_i), .blank_i(blank_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .rgb_o(rgb_o),
    .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  // R5: logo pixel in output order {red, green, blue}
  function automatic logic [23:0] expect_logo(int s, int c);
    logic [7:0] red, green, blue;
    red   = 8'(255 - ((c ^ (s << 2)) & 255));
    green = 8'((c * 5 + s) % 256);
    blue  = 8'(((s * 37) % 256) ^ c);
    return {red, green, blue};
  endfunction

  function automatic logic [23:0] src_pix(int x, int y, int f);
    return {8'(x ^ 8'h5A), 8'(y * 16 + f), 8'(x + 3 * y + 7)};
  endfunction

  task automatic check_prev();
    if (exp_valid) begin
      vectors++;
      if ({blank_o, hsync_o, vsync_o} != {exp_blank, exp_hs, exp_vs}) begin
        miscompares++;
        $display("FAIL R1 syncs: got %b%b%b expected %b%b%b",
                 blank_o, hsync_o, vsync_o, exp_blank, exp_hs, exp_vs);
      end
      if (rgb_o != exp_rgb) begin
        miscompares++;
        $display("FAIL %s colour: got %06h expected %06h", exp_tag, rgb_o, exp_rgb);
      end
    end
  endtask

  // Drive one pixel at a falling edge; check the previous one first
  task automatic step(logic b, logic hs, logic vs, logic [23:0] pix, int x, int y);
    @(negedge clk);
    check_prev();
    blank_i = b; hsync_i = hs; vsync_i = vs; rgb_i = pix;
    exp_valid = 1'b1;
    exp_blank = b; exp_hs = hs; exp_vs = vs;
    if (!b && x >= AW - LW && x < AW && y < LH) begin
      // R4 window, R2/R3 position, R6 bottom-up row and column offset
      exp_rgb = expect_logo(LH - 1 - y, x - (AW - LW));
      exp_tag = "R5/R6";
    end else begin
      exp_rgb = pix;
      exp_tag = (!b && (x >= AW || y >= LH)) ? "R8" : "R7";
    end
  endtask

  task automatic send_line(bit active, bit vs, int width, int y, int f);
    for (int x = 0; x < width; x++)
      step(!active, 1'b0, vs, src_pix(x, y, f), x, y);
    for (int k = 0; k < HB; k++)
      step(1'b1, (k == 1 || k == 2), vs, src_pix(100 + k, y, f), 0, y);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R9: drive non-idle inputs under reset; outputs must hold reset values
    blank_i = 1'b0; hsync_i = 1'b1; vsync_i = 1'b1; rgb_i = 24'hABCDEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (!(blank_o === 1'b1 && hsync_o === 1'b0 && vsync_o === 1'b0 && rgb_o === 24'h0)) begin
      miscompares++;
      $display("FAIL R9 reset: got %b%b%b %06h expected 100 000000",
               blank_o, hsync_o, vsync_o, rgb_o);
    end
    blank_i = 1'b1; hsync_i = 1'b0; vsync_i = 1'b0; rgb_i = '0;
    rst = 1'b0;

    for (int f = 0; f < 3; f++) begin
      int w;
      w = (f == 2) ? AW + 3 : AW;   // R8: over-long lines in the last frame
      send_line(1'b0, 1'b0, w, 0, f);
      send_line(1'b0, 1'b1, w, 0, f); // R3: vsync clears the row count
      send_line(1'b0, 1'b0, w, 0, f);
      for (int y = 0; y < LINES; y++)
        send_line(1'b1, 1'b0, w, y, f);
    end
    step(1'b1, 1'b0, 1'b0, 24'h0, 0, 0);
    @(negedge clk);
    check_prev();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule